// File: doc/BRIEF.md
# Mixed-Width Register Transfer Unit

This block is the user-visible register set of an 8/16-bit processor core: an accumulator, two index registers, a stack pointer and a direct-page base. It carries out copies between these registers, the byte swap of the accumulator, immediate loads and the changes of width and emulation mode. Each operation arrives as a code with a valid strobe and retires at the next rising clock edge. Register contents and the negative, zero, carry, width and emulation flags are driven straight from flops.

The accumulator width flag and the index width flag decide how many bits an operation moves. When the accumulator is 8 bits, its upper byte stays hidden but is kept intact. When the index registers are 8 bits, their upper bytes are held at zero. Transfers between the accumulator and the stack pointer or the direct-page base always move all 16 bits. The accumulator viewed at full width is called C below, and its hidden upper byte is called B.

Top module: `mrt_unit`

## Requirements
- R1: After a clock edge with rst_n low, the accumulator, both index registers and the direct-page base read 0x0000 and the stack pointer reads 0x01FF. Emulation, accumulator-8 and index-8 flags read 1. Carry, negative and zero read 0.
- R2: The destination's width decides how much is written. When the index width is 8 bits, an operation that writes X or Y writes only the low byte of the source, and the upper byte reads 0. The operations affected are A to X (code 1), A to Y (code 2), S to X (code 5) and load X or Y (codes 16 and 17).
- R3: While the index-8 flag is 1, the upper bytes of X and Y read 0. Setting that flag clears them, so the registers read zero-extended after a later return to 16 bits.
- R4: With the accumulator at 8 bits, X to A (code 3), Y to A (code 4) and load A (code 15) change only the low byte. The upper byte B keeps its value, including across a switch from 16 to 8 bits.
- R5: With an 8-bit accumulator and 16-bit index registers, A to X or A to Y copies the full value {B, A}.
- R6: With an 8-bit index register and a 16-bit accumulator, X to A or Y to A writes the index value zero-extended.
- R7: Four operations always move 16 bits, whatever the accumulator width: C to D (code 9), D to C (code 10), C to S (code 11) and S to C (code 12). Codes 10 and 12 also write B when the accumulator is 8 bits.
- R8: Transfers, loads and the byte swap set negative from the top bit and zero from all bits, both taken at the destination's width, of the value moved. X to S (code 6), X to Y (code 7) and Y to X (code 8) follow the same rule except X to S, which leaves both flags unchanged. Width, carry and mode operations also leave both flags unchanged.
- R9: The byte swap (code 13) exchanges the two accumulator bytes. Negative takes bit 7 of the new low byte in either width. Zero covers the low byte when the accumulator is 8 bits and all 16 bits otherwise.
- R10: The mode swap (code 14) exchanges carry and the emulation flag. While emulation is 1, both width flags read 1, the stack pointer's upper byte reads 0x01, and a clear-width request is ignored. A stack write keeps only its low byte.
- R11: While op_valid is low, no output changes.
- R12: Codes 18 and 19 set and clear width flags: op_data bit 1 selects the accumulator flag and bit 0 selects the index flag. Codes 20 and 21 set and clear carry. Code 0 and codes 22 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 5 | Operation code |
| op_data | input | 16 | Immediate value for loads and width masks |
| acc_out | output | 16 | Accumulator, full 16 bits |
| idx_x_out | output | 16 | Index register X |
| idx_y_out | output | 16 | Index register Y |
| stack_out | output | 16 | Stack pointer |
| dpage_out | output | 16 | Direct-page base |
| flag_neg | output | 1 | Negative flag |
| flag_zero | output | 1 | Zero flag |
| flag_carry | output | 1 | Carry flag |
| flag_acc8 | output | 1 | Accumulator is 8 bits |
| flag_idx8 | output | 1 | Index registers are 8 bits |
| flag_emu | output | 1 | Emulation mode |

## Verification
The hardest state to reach is an 8-bit accumulator whose hidden byte is non-zero and known, combined with 16-bit index registers. That state only arises from a 16-bit load followed by a width change and then a clear of only the index flag. The stimulus table first leaves emulation through the mode swap, loads the accumulator at 16 bits, and narrows it. It then widens only the index registers, so that the A-to-X copy shows B in the upper byte. A later pass returns to emulation with non-zero upper bytes in X, Y and S, and checks that the mode change forces them.

// File: rtl/mrt_pkg.sv
// Package: shared operation codes, routing enums and the decoded control word
// for the mixed-width register transfer unit.
package mrt_pkg;

    localparam int OP_W        = 5;
    localparam int SEL_ACC_BIT = 1;   // op_data bit picking the accumulator width flag
    localparam int SEL_IDX_BIT = 0;   // op_data bit picking the index width flag

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 5'd0,
        OP_A2X  = 5'd1,
        OP_A2Y  = 5'd2,
        OP_X2A  = 5'd3,
        OP_Y2A  = 5'd4,
        OP_S2X  = 5'd5,
        OP_X2S  = 5'd6,
        OP_X2Y  = 5'd7,
        OP_Y2X  = 5'd8,
        OP_C2D  = 5'd9,
        OP_D2C  = 5'd10,
        OP_C2S  = 5'd11,
        OP_S2C  = 5'd12,
        OP_SWAB = 5'd13,
        OP_MSWP = 5'd14,
        OP_LDA  = 5'd15,
        OP_LDX  = 5'd16,
        OP_LDY  = 5'd17,
        OP_WSET = 5'd18,
        OP_WCLR = 5'd19,
        OP_CSET = 5'd20,
        OP_CCLR = 5'd21
    } op_e;

    typedef enum logic [2:0] {
        SRC_C, SRC_X, SRC_Y, SRC_S, SRC_D, SRC_IMM, SRC_SWAP
    } src_e;

    // DST_A honours the accumulator width; DST_C always writes 16 bits.
    typedef enum logic [2:0] {
        DST_NONE, DST_A, DST_C, DST_X, DST_Y, DST_S, DST_D
    } dst_e;

    typedef struct packed {
        src_e src;
        dst_e dst;
        logic nz_en;
        logic n_low;
        logic w_set;
        logic w_clr;
        logic c_set;
        logic c_clr;
        logic mode_swap;
    } ctl_t;

endpackage

// File: rtl/mrt_decode.sv
// Decoder: turns a strobed operation code into a control word.
// Assumes: an invalid strobe or an unknown code yields a word that changes nothing.
module mrt_decode
    import mrt_pkg::*;
(
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    output ctl_t            ctl
);

    // Map each code to its source, destination and side effects.
    always_comb begin
        ctl           = '0;
        ctl.src       = SRC_C;
        ctl.dst       = DST_NONE;
        if (op_valid) begin
            case (op_code)
                OP_A2X:  begin ctl.src = SRC_C;    ctl.dst = DST_X; ctl.nz_en = 1'b1; end
                OP_A2Y:  begin ctl.src = SRC_C;    ctl.dst = DST_Y; ctl.nz_en = 1'b1; end
                OP_X2A:  begin ctl.src = SRC_X;    ctl.dst = DST_A; ctl.nz_en = 1'b1; end
                OP_Y2A:  begin ctl.src = SRC_Y;    ctl.dst = DST_A; ctl.nz_en = 1'b1; end
                OP_S2X:  begin ctl.src = SRC_S;    ctl.dst = DST_X; ctl.nz_en = 1'b1; end
                OP_X2S:  begin ctl.src = SRC_X;    ctl.dst = DST_S; end
                OP_X2Y:  begin ctl.src = SRC_X;    ctl.dst = DST_Y; ctl.nz_en = 1'b1; end
                OP_Y2X:  begin ctl.src = SRC_Y;    ctl.dst = DST_X; ctl.nz_en = 1'b1; end
                OP_C2D:  begin ctl.src = SRC_C;    ctl.dst = DST_D; ctl.nz_en = 1'b1; end
                OP_D2C:  begin ctl.src = SRC_D;    ctl.dst = DST_C; ctl.nz_en = 1'b1; end
                OP_C2S:  begin ctl.src = SRC_C;    ctl.dst = DST_S; ctl.nz_en = 1'b1; end
                OP_S2C:  begin ctl.src = SRC_S;    ctl.dst = DST_C; ctl.nz_en = 1'b1; end
                OP_SWAB: begin ctl.src = SRC_SWAP; ctl.dst = DST_C; ctl.nz_en = 1'b1;
                               ctl.n_low = 1'b1; end
                OP_MSWP: ctl.mode_swap = 1'b1;
                OP_LDA:  begin ctl.src = SRC_IMM;  ctl.dst = DST_A; ctl.nz_en = 1'b1; end
                OP_LDX:  begin ctl.src = SRC_IMM;  ctl.dst = DST_X; ctl.nz_en = 1'b1; end
                OP_LDY:  begin ctl.src = SRC_IMM;  ctl.dst = DST_Y; ctl.nz_en = 1'b1; end
                OP_WSET: ctl.w_set = 1'b1;
                OP_WCLR: ctl.w_clr = 1'b1;
                OP_CSET: ctl.c_set = 1'b1;
                OP_CCLR: ctl.c_clr = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/mrt_datapath.sv
// Datapath: selects the source value and forms every register's next value.
// Assumes: writes use the current widths; the next-cycle width and emulation
// flags then mask the index upper bytes and the stack page.
module mrt_datapath
    import mrt_pkg::*;
#(
    parameter int               BYTE_W     = 8,
    parameter logic [BYTE_W-1:0] STACK_PAGE = 'd1
) (
    input  ctl_t                  ctl,
    input  logic [2*BYTE_W-1:0]   imm,
    input  logic [2*BYTE_W-1:0]   acc_q,
    input  logic [2*BYTE_W-1:0]   x_q,
    input  logic [2*BYTE_W-1:0]   y_q,
    input  logic [2*BYTE_W-1:0]   s_q,
    input  logic [2*BYTE_W-1:0]   d_q,
    input  logic                  acc8_q,
    input  logic                  idx8_q,
    input  logic                  idx8_nx,
    input  logic                  emu_nx,
    output logic [2*BYTE_W-1:0]   acc_nx,
    output logic [2*BYTE_W-1:0]   x_nx,
    output logic [2*BYTE_W-1:0]   y_nx,
    output logic [2*BYTE_W-1:0]   s_nx,
    output logic [2*BYTE_W-1:0]   d_nx,
    output logic [2*BYTE_W-1:0]   nz_val,
    output logic                  nz_wide
);

    localparam int WORD_W  = 2 * BYTE_W;
    localparam int NUM_IDX = 2;

    logic [WORD_W-1:0] src_val;
    logic [WORD_W-1:0] idx_q  [NUM_IDX];
    logic [WORD_W-1:0] idx_nx [NUM_IDX];
    logic [WORD_W-1:0] s_wr;

    // Source selection.
    always_comb begin
        case (ctl.src)
            SRC_C:    src_val = acc_q;
            SRC_X:    src_val = x_q;
            SRC_Y:    src_val = y_q;
            SRC_S:    src_val = s_q;
            SRC_D:    src_val = d_q;
            SRC_IMM:  src_val = imm;
            SRC_SWAP: src_val = {acc_q[BYTE_W-1:0], acc_q[WORD_W-1:BYTE_W]};
            default:  src_val = acc_q;
        endcase
    end

    // Accumulator write: low byte only when narrow, unless forced to 16 bits.
    always_comb begin
        acc_nx = acc_q;
        if (ctl.dst == DST_C)
            acc_nx = src_val;
        else if (ctl.dst == DST_A)
            acc_nx = acc8_q ? {acc_q[WORD_W-1:BYTE_W], src_val[BYTE_W-1:0]} : src_val;
    end

    assign idx_q[0] = x_q;
    assign idx_q[1] = y_q;

    // Index registers: same width rule for X and Y, upper byte zeroed when narrow.
    for (genvar gi = 0; gi < NUM_IDX; gi++) begin : g_idx
        localparam dst_e MY_DST = (gi == 0) ? DST_X : DST_Y;
        logic [WORD_W-1:0] wr;

        // Write then mask against the next-cycle index width.
        always_comb begin
            wr = idx_q[gi];
            if (ctl.dst == MY_DST)
                wr = idx8_q ? {{BYTE_W{1'b0}}, src_val[BYTE_W-1:0]} : src_val;
            idx_nx[gi] = idx8_nx ? {{BYTE_W{1'b0}}, wr[BYTE_W-1:0]} : wr;
        end
    end

    assign x_nx = idx_nx[0];
    assign y_nx = idx_nx[1];

    // Stack pointer: full write, page forced while emulating.
    always_comb begin
        s_wr = (ctl.dst == DST_S) ? src_val : s_q;
        s_nx = emu_nx ? {STACK_PAGE, s_wr[BYTE_W-1:0]} : s_wr;
    end

    // Direct-page base: always a full 16-bit write.
    assign d_nx = (ctl.dst == DST_D) ? src_val : d_q;

    // Flag source: the moved value, judged at the destination's width.
    always_comb begin
        nz_val = src_val;
        case (ctl.dst)
            DST_A:        nz_wide = !acc8_q;
            DST_X, DST_Y: nz_wide = !idx8_q;
            default:      nz_wide = 1'b1;
        endcase
        if (ctl.n_low)
            nz_wide = !acc8_q;
    end

endmodule

// File: rtl/mrt_flag_eval.sv
// Flag evaluator: negative and zero of a value at byte or word width.
// Assumes: n_low forces the sign from bit BYTE_W-1 whatever the width.
module mrt_flag_eval #(
    parameter int BYTE_W = 8
) (
    input  logic [2*BYTE_W-1:0] val,
    input  logic                wide,
    input  logic                n_low,
    output logic                neg,
    output logic                zero
);

    localparam int WORD_W = 2 * BYTE_W;

    // Sign and zero test at the chosen width.
    always_comb begin
        neg  = (wide && !n_low) ? val[WORD_W-1] : val[BYTE_W-1];
        zero = wide ? (val == '0) : (val[BYTE_W-1:0] == '0);
    end

endmodule

// File: rtl/mrt_unit.sv
// Top: register set with mixed-width transfers, byte swap, loads and mode control.
// Assumes: one operation per cycle, each retiring at the next rising edge;
// synchronous active-low reset.
module mrt_unit
    import mrt_pkg::*;
#(
    parameter int                BYTE_W     = 8,
    parameter logic [BYTE_W-1:0] STACK_PAGE = 'd1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [OP_W-1:0]     op_code,
    input  logic [2*BYTE_W-1:0] op_data,
    output logic [2*BYTE_W-1:0] acc_out,
    output logic [2*BYTE_W-1:0] idx_x_out,
    output logic [2*BYTE_W-1:0] idx_y_out,
    output logic [2*BYTE_W-1:0] stack_out,
    output logic [2*BYTE_W-1:0] dpage_out,
    output logic                flag_neg,
    output logic                flag_zero,
    output logic                flag_carry,
    output logic                flag_acc8,
    output logic                flag_idx8,
    output logic                flag_emu
);

    localparam int WORD_W = 2 * BYTE_W;
    localparam logic [WORD_W-1:0] RST_STACK = {STACK_PAGE, {BYTE_W{1'b1}}};

    ctl_t              ctl;
    logic [WORD_W-1:0] acc_q, x_q, y_q, s_q, d_q;
    logic [WORD_W-1:0] acc_nx, x_nx, y_nx, s_nx, d_nx, nz_val;
    logic              nz_wide, n_new, z_new;
    logic              neg_q, zero_q, carry_q, acc8_q, idx8_q, emu_q;
    logic              carry_nx, acc8_nx, idx8_nx, emu_nx;

    mrt_decode u_decode (
        .op_valid (op_valid),
        .op_code  (op_code),
        .ctl      (ctl)
    );

    // Mode flags: swap carry with emulation, apply width masks, force narrow in emulation.
    always_comb begin
        emu_nx   = ctl.mode_swap ? carry_q : emu_q;
        carry_nx = carry_q;
        if (ctl.mode_swap)  carry_nx = emu_q;
        else if (ctl.c_set) carry_nx = 1'b1;
        else if (ctl.c_clr) carry_nx = 1'b0;

        acc8_nx = acc8_q;
        idx8_nx = idx8_q;
        if (ctl.w_set) begin
            acc8_nx = acc8_q | op_data[SEL_ACC_BIT];
            idx8_nx = idx8_q | op_data[SEL_IDX_BIT];
        end else if (ctl.w_clr) begin
            acc8_nx = acc8_q & ~op_data[SEL_ACC_BIT];
            idx8_nx = idx8_q & ~op_data[SEL_IDX_BIT];
        end
        if (emu_nx) begin
            acc8_nx = 1'b1;
            idx8_nx = 1'b1;
        end
    end

    mrt_datapath #(
        .BYTE_W     (BYTE_W),
        .STACK_PAGE (STACK_PAGE)
    ) u_datapath (
        .ctl     (ctl),
        .imm     (op_data),
        .acc_q   (acc_q),
        .x_q     (x_q),
        .y_q     (y_q),
        .s_q     (s_q),
        .d_q     (d_q),
        .acc8_q  (acc8_q),
        .idx8_q  (idx8_q),
        .idx8_nx (idx8_nx),
        .emu_nx  (emu_nx),
        .acc_nx  (acc_nx),
        .x_nx    (x_nx),
        .y_nx    (y_nx),
        .s_nx    (s_nx),
        .d_nx    (d_nx),
        .nz_val  (nz_val),
        .nz_wide (nz_wide)
    );

    mrt_flag_eval #(
        .BYTE_W (BYTE_W)
    ) u_flags (
        .val   (nz_val),
        .wide  (nz_wide),
        .n_low (ctl.n_low),
        .neg   (n_new),
        .zero  (z_new)
    );

    // Register state update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            x_q     <= '0;
            y_q     <= '0;
            s_q     <= RST_STACK;
            d_q     <= '0;
            neg_q   <= 1'b0;
            zero_q  <= 1'b0;
            carry_q <= 1'b0;
            acc8_q  <= 1'b1;
            idx8_q  <= 1'b1;
            emu_q   <= 1'b1;
        end else begin
            acc_q   <= acc_nx;
            x_q     <= x_nx;
            y_q     <= y_nx;
            s_q     <= s_nx;
            d_q     <= d_nx;
            carry_q <= carry_nx;
            acc8_q  <= acc8_nx;
            idx8_q  <= idx8_nx;
            emu_q   <= emu_nx;
            if (ctl.nz_en) begin
                neg_q  <= n_new;
                zero_q <= z_new;
            end
        end
    end

    assign acc_out    = acc_q;
    assign idx_x_out  = x_q;
    assign idx_y_out  = y_q;
    assign stack_out  = s_q;
    assign dpage_out  = d_q;
    assign flag_neg   = neg_q;
    assign flag_zero  = zero_q;
    assign flag_carry = carry_q;
    assign flag_acc8  = acc8_q;
    assign flag_idx8  = idx8_q;
    assign flag_emu   = emu_q;

endmodule

// File: rtl/mrt_unit_chk.sv
// Checker: temporal properties on the ports of mrt_unit, attached by bind.
// Assumes: synchronous active-low reset; properties are disabled while it is low.
module mrt_unit_chk
    import mrt_pkg::*;
#(
    parameter int                BYTE_W     = 8,
    parameter logic [BYTE_W-1:0] STACK_PAGE = 'd1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                op_valid,
    input logic [OP_W-1:0]     op_code,
    input logic [2*BYTE_W-1:0] acc_out,
    input logic [2*BYTE_W-1:0] idx_x_out,
    input logic [2*BYTE_W-1:0] idx_y_out,
    input logic [2*BYTE_W-1:0] stack_out,
    input logic [2*BYTE_W-1:0] dpage_out,
    input logic                flag_neg,
    input logic                flag_zero,
    input logic                flag_carry,
    input logic                flag_acc8,
    input logic                flag_idx8,
    input logic                flag_emu
);

    localparam int WORD_W = 2 * BYTE_W;

    // R3: narrow index registers never show an upper byte.
    a_r3_idx_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flag_idx8 |-> (idx_x_out[WORD_W-1:BYTE_W] == '0 && idx_y_out[WORD_W-1:BYTE_W] == '0));

    // R4: narrow accumulator writes keep the hidden byte.
    a_r4_hidden_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && flag_acc8 && (op_code == OP_X2A || op_code == OP_Y2A || op_code == OP_LDA))
        |=> $stable(acc_out[WORD_W-1:BYTE_W]));

    // R7: stack to accumulator always moves the full word.
    a_r7_s2c_full: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_S2C) |=> (acc_out == $past(stack_out)));

    // R8: stack load from X leaves negative and zero alone.
    a_r8_x2s_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_X2S) |=> ($stable(flag_neg) && $stable(flag_zero)));

    // R9: byte swap exchanges the accumulator halves.
    a_r9_swap_bytes: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SWAB)
        |=> (acc_out == {$past(acc_out[BYTE_W-1:0]), $past(acc_out[WORD_W-1:BYTE_W])}));

    // R10: emulation forces narrow widths and the fixed stack page.
    a_r10_emul_modes: assert property (@(posedge clk) disable iff (!rst_n)
        flag_emu |-> (flag_acc8 && flag_idx8 && stack_out[WORD_W-1:BYTE_W] == STACK_PAGE));

    // R11: no strobe, no change.
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable({acc_out, idx_x_out, idx_y_out, stack_out, dpage_out,
                               flag_neg, flag_zero, flag_carry, flag_acc8, flag_idx8, flag_emu}));

endmodule

bind mrt_unit mrt_unit_chk #(
    .BYTE_W     (BYTE_W),
    .STACK_PAGE (STACK_PAGE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .acc_out    (acc_out),
    .idx_x_out  (idx_x_out),
    .idx_y_out  (idx_y_out),
    .stack_out  (stack_out),
    .dpage_out  (dpage_out),
    .flag_neg   (flag_neg),
    .flag_zero  (flag_zero),
    .flag_carry (flag_carry),
    .flag_acc8  (flag_acc8),
    .flag_idx8  (flag_idx8),
    .flag_emu   (flag_emu)
);

// File: tb/mrt_unit_tb.sv
module mrt_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 44;

    typedef struct packed {
        logic [4:0]  op;
        logic [15:0] dat;
        logic [15:0] a;
        logic [15:0] x;
        logic [15:0] y;
        logic [15:0] s;
        logic [15:0] d;
        logic [5:0]  f;     // {neg, zero, carry, acc8, idx8, emu}
    } vec_t;

    // Cumulative sequence from reset; each row is the state after its operation.
    localparam vec_t VECS [NVEC] = '{
        '{5'd21, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 6'b000111}, // R12 clear carry
        '{5'd14, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 6'b001110}, // R10 leave emulation
        '{5'd19, 16'h0003, 16'h0000, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 6'b001000}, // R12 both wide
        '{5'd15, 16'h7F33, 16'h7F33, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 6'b001000}, // R8 load A
        '{5'd16, 16'h1234, 16'h7F33, 16'h1234, 16'h0000, 16'h01FF, 16'h0000, 6'b001000},
        '{5'd2,  16'h0000, 16'h7F33, 16'h1234, 16'h7F33, 16'h01FF, 16'h0000, 6'b001000},
        '{5'd18, 16'h0001, 16'h7F33, 16'h0034, 16'h0033, 16'h01FF, 16'h0000, 6'b001010}, // R3 narrow index
        '{5'd1,  16'h0000, 16'h7F33, 16'h0033, 16'h0033, 16'h01FF, 16'h0000, 6'b001010}, // R2
        '{5'd15, 16'h8000, 16'h8000, 16'h0033, 16'h0033, 16'h01FF, 16'h0000, 6'b101010}, // R8 negative
        '{5'd2,  16'h0000, 16'h8000, 16'h0033, 16'h0000, 16'h01FF, 16'h0000, 6'b011010}, // R2 R8 zero at byte
        '{5'd3,  16'h0000, 16'h0033, 16'h0033, 16'h0000, 16'h01FF, 16'h0000, 6'b001010}, // R6
        '{5'd15, 16'h7FFF, 16'h7FFF, 16'h0033, 16'h0000, 16'h01FF, 16'h0000, 6'b001010},
        '{5'd18, 16'h0002, 16'h7FFF, 16'h0033, 16'h0000, 16'h01FF, 16'h0000, 6'b001110}, // R4 narrow A
        '{5'd15, 16'h0080, 16'h7F80, 16'h0033, 16'h0000, 16'h01FF, 16'h0000, 6'b101110}, // R4
        '{5'd4,  16'h0000, 16'h7F00, 16'h0033, 16'h0000, 16'h01FF, 16'h0000, 6'b011110}, // R4
        '{5'd19, 16'h0001, 16'h7F00, 16'h0033, 16'h0000, 16'h01FF, 16'h0000, 6'b011100}, // R3 wide index
        '{5'd1,  16'h0000, 16'h7F00, 16'h7F00, 16'h0000, 16'h01FF, 16'h0000, 6'b001100}, // R5
        '{5'd17, 16'hFFFF, 16'h7F00, 16'h7F00, 16'hFFFF, 16'h01FF, 16'h0000, 6'b101100},
        '{5'd4,  16'h0000, 16'h7FFF, 16'h7F00, 16'hFFFF, 16'h01FF, 16'h0000, 6'b101100}, // R4
        '{5'd10, 16'h0000, 16'h0000, 16'h7F00, 16'hFFFF, 16'h01FF, 16'h0000, 6'b011100}, // R7 writes B
        '{5'd15, 16'h0012, 16'h0012, 16'h7F00, 16'hFFFF, 16'h01FF, 16'h0000, 6'b001100},
        '{5'd13, 16'h0000, 16'h1200, 16'h7F00, 16'hFFFF, 16'h01FF, 16'h0000, 6'b011100}, // R9 narrow
        '{5'd9,  16'h0000, 16'h1200, 16'h7F00, 16'hFFFF, 16'h01FF, 16'h1200, 6'b001100}, // R7
        '{5'd15, 16'h00C5, 16'h12C5, 16'h7F00, 16'hFFFF, 16'h01FF, 16'h1200, 6'b101100},
        '{5'd11, 16'h0000, 16'h12C5, 16'h7F00, 16'hFFFF, 16'h12C5, 16'h1200, 6'b001100}, // R7
        '{5'd5,  16'h0000, 16'h12C5, 16'h12C5, 16'hFFFF, 16'h12C5, 16'h1200, 6'b001100},
        '{5'd16, 16'h8001, 16'h12C5, 16'h8001, 16'hFFFF, 16'h12C5, 16'h1200, 6'b101100},
        '{5'd6,  16'h0000, 16'h12C5, 16'h8001, 16'hFFFF, 16'h8001, 16'h1200, 6'b101100}, // R8 no flags
        '{5'd12, 16'h0000, 16'h8001, 16'h8001, 16'hFFFF, 16'h8001, 16'h1200, 6'b101100}, // R7
        '{5'd19, 16'h0002, 16'h8001, 16'h8001, 16'hFFFF, 16'h8001, 16'h1200, 6'b101000},
        '{5'd13, 16'h0000, 16'h0180, 16'h8001, 16'hFFFF, 16'h8001, 16'h1200, 6'b101000}, // R9 wide
        '{5'd7,  16'h0000, 16'h0180, 16'h8001, 16'h8001, 16'h8001, 16'h1200, 6'b101000},
        '{5'd16, 16'h0000, 16'h0180, 16'h0000, 16'h8001, 16'h8001, 16'h1200, 6'b011000},
        '{5'd8,  16'h0000, 16'h0180, 16'h8001, 16'h8001, 16'h8001, 16'h1200, 6'b101000},
        '{5'd21, 16'h0000, 16'h0180, 16'h8001, 16'h8001, 16'h8001, 16'h1200, 6'b100000}, // R12
        '{5'd20, 16'h0000, 16'h0180, 16'h8001, 16'h8001, 16'h8001, 16'h1200, 6'b101000}, // R12
        '{5'd14, 16'h0000, 16'h0180, 16'h0001, 16'h0001, 16'h0101, 16'h1200, 6'b100111}, // R10 enter
        '{5'd19, 16'h0003, 16'h0180, 16'h0001, 16'h0001, 16'h0101, 16'h1200, 6'b100111}, // R10 ignored
        '{5'd0,  16'hFFFF, 16'h0180, 16'h0001, 16'h0001, 16'h0101, 16'h1200, 6'b100111}, // R12 no-op
        '{5'd25, 16'hFFFF, 16'h0180, 16'h0001, 16'h0001, 16'h0101, 16'h1200, 6'b100111}, // R12 unused
        '{5'd16, 16'hABCD, 16'h0180, 16'h00CD, 16'h0001, 16'h0101, 16'h1200, 6'b100111}, // R2
        '{5'd6,  16'h0000, 16'h0180, 16'h00CD, 16'h0001, 16'h01CD, 16'h1200, 6'b100111}, // R10 page
        '{5'd13, 16'h0000, 16'h8001, 16'h00CD, 16'h0001, 16'h01CD, 16'h1200, 6'b000111}, // R9
        '{5'd11, 16'h0000, 16'h8001, 16'h00CD, 16'h0001, 16'h0101, 16'h1200, 6'b100111}  // R10 R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [15:0] op_data = '0;
    logic [15:0] acc_out, idx_x_out, idx_y_out, stack_out, dpage_out;
    logic        flag_neg, flag_zero, flag_carry, flag_acc8, flag_idx8, flag_emu;
    int          checks = 0;
    int          failures = 0;
    logic        done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mrt_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_code    (op_code),
        .op_data    (op_data),
        .acc_out    (acc_out),
        .idx_x_out  (idx_x_out),
        .idx_y_out  (idx_y_out),
        .stack_out  (stack_out),
        .dpage_out  (dpage_out),
        .flag_neg   (flag_neg),
        .flag_zero  (flag_zero),
        .flag_carry (flag_carry),
        .flag_acc8  (flag_acc8),
        .flag_idx8  (flag_idx8),
        .flag_emu   (flag_emu)
    );

    task automatic check_state(input string tag, input logic [15:0] a, input logic [15:0] x,
                               input logic [15:0] y, input logic [15:0] s, input logic [15:0] d,
                               input logic [5:0] f);
        logic [5:0] fa;
        fa = {flag_neg, flag_zero, flag_carry, flag_acc8, flag_idx8, flag_emu};
        checks++;
        if (acc_out !== a || idx_x_out !== x || idx_y_out !== y || stack_out !== s ||
            dpage_out !== d || fa !== f) begin
            failures++;
            $display("FAIL %s: got a=%h x=%h y=%h s=%h d=%h f=%b, expected a=%h x=%h y=%h s=%h d=%h f=%b",
                     tag, acc_out, idx_x_out, idx_y_out, stack_out, dpage_out, fa,
                     a, x, y, s, d, f);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: state right after reset
        check_state("R1 reset", 16'h0000, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 6'b000111);

        // R10: clear-width is ignored while emulating
        op_valid = 1'b1; op_code = 5'd19; op_data = 16'h0003;
        @(negedge clk);
        op_valid = 1'b0;
        check_state("R10 clear ignored", 16'h0000, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 6'b000111);

        for (int i = 0; i < NVEC; i++) begin
            op_valid = 1'b1;
            op_code  = VECS[i].op;
            op_data  = VECS[i].dat;
            @(negedge clk);
            op_valid = 1'b0;
            check_state($sformatf("vector %0d", i), VECS[i].a, VECS[i].x, VECS[i].y,
                        VECS[i].s, VECS[i].d, VECS[i].f);
        end

        // R11: a strobe-less cycle with a live code must change nothing
        op_valid = 1'b0; op_code = 5'd12; op_data = 16'hFFFF;
        repeat (3) @(negedge clk);
        check_state("R11 idle", 16'h8001, 16'h00CD, 16'h0001, 16'h0101, 16'h1200, 6'b100111);

        // R1: reset from a busy state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_state("R1 re-reset", 16'h0000, 16'h0000, 16'h0000, 16'h01FF, 16'h0000, 6'b000111);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule